// File: doc/BRIEF.md
# Set-Associative Cache Tag Model with LRU Replacement

This block replays a stream of memory operations against a tag-only model of a set-associative cache. It decides, for each data access, whether the access hits or misses and whether the miss displaces a valid line. It also keeps running totals from which a hit ratio and an average access time can be derived: one cycle of hit time plus the miss ratio times a 100-cycle penalty. It stores no data, so there is no write-back traffic and no memory port. Parameters set the geometry. One way per set gives a direct-mapped cache, and zero index bits give a fully associative one.

Each operation arrives on a valid/ready handshake and carries a two-bit operation code and a byte address. Loads and stores are single accesses. A modify is replayed as a load followed by a store to the same address over two cycles, and the block holds off new input while the store part runs. Instruction fetches are accepted and discarded. Access size is not an input: every access is taken as aligned.

Replacement fills an empty way before it displaces anything. When the set is full, it evicts the least recently used way, which it finds from a per-way age rank.

Top module: `cache_tag_lru`

## Requirements
- R1: The address is split as offset = addr[OFF_BITS-1:0], set index = the next SET_BITS bits, and tag = the remaining upper bits. Addresses that differ only in the offset reach the same block, and the set index alone selects the set.
- R2: An access hits only when some way of the indexed set is valid and holds the access tag. Each reported result has exactly one of hit and miss set.
- R3: On a miss with at least one invalid way in the set, the lowest-numbered invalid way is filled and no eviction is reported.
- R4: On a miss in a full set, the least recently used way is replaced and eviction is reported together with the miss.
- R5: A hit or a fill makes the accessed way most recent. Every way that was more recent than it ages by one.
- R6: Operation codes are 0 = fetch, 1 = load, 2 = store, 3 = modify. A modify is accepted in one cycle as a load. In_ready is low in the next cycle while its store runs, and that store always hits.
- R7: A fetch is accepted and has no effect. It produces no result and changes no counter and no cache state.
- R8: A store that misses allocates a line in the same way a load does.
- R9: The hit, miss and eviction counters and the data-access counter each increase by one for every access of that kind.
- R10: Reset clears every valid bit, every counter and the result outputs.
- R11: The result of an access is on the result outputs in the cycle after the access is taken.
- R12: With 16 sets, 1 way and 16-byte blocks, the sequence L 0x10, M 0x20, L 0x22, S 0x18, L 0x110, L 0x210, M 0x12 yields 4 hits, 5 misses, 3 evictions and 9 accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken (low during the store part of a modify) |
| in_op | input | 2 | 0 fetch, 1 load, 2 store, 3 modify |
| in_addr | input | ADDR_W | Byte address |
| res_valid | output | 1 | Result of one data access is present |
| res_hit | output | 1 | Access hit |
| res_miss | output | 1 | Access missed |
| res_evict | output | 1 | Miss displaced a valid line |
| hit_cnt | output | CNT_W | Total hits |
| miss_cnt | output | CNT_W | Total misses |
| evict_cnt | output | CNT_W | Total evictions |
| access_cnt | output | CNT_W | Total data accesses |

## Verification
A taken access updates the cache state, the result outputs and all four counters on the same rising edge. Its result can therefore be read one edge after the operation is presented. For a modify, the load result is due one edge after the operation is presented and the store result one edge after that. The bench drives on falling edges and samples on the next falling edge, so each check falls half a period after the edge that produced its value. For a modify, the bench samples again one full period later and checks in between that in_ready is low.

// File: rtl/cache_tag_lru.sv
module cache_tag_lru #(
  parameter int ADDR_W   = 32,
  parameter int SET_BITS = 2,
  parameter int WAYS     = 4,
  parameter int OFF_BITS = 4,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_evict,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  miss_cnt,
  output logic [CNT_W-1:0]  evict_cnt,
  output logic [CNT_W-1:0]  access_cnt
);
  localparam int SETS   = 1 << SET_BITS;
  localparam int SIDX_W = (SET_BITS > 0) ? SET_BITS : 1;
  localparam int TAG_W  = ADDR_W - SET_BITS - OFF_BITS;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [1:0] OP_FETCH = 2'd0;
  localparam logic [1:0] OP_MOD   = 2'd3;

  logic             vld  [SETS][WAYS];
  logic [TAG_W-1:0] tags [SETS][WAYS];
  logic [WAY_W-1:0] age  [SETS][WAYS];

  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic              take, go;
  logic [ADDR_W-1:0] acc_addr;
  logic [SIDX_W-1:0] set_i;
  logic [TAG_W-1:0]  tag_i;
  logic              hit, have_inv, evict;
  logic [WAY_W-1:0]  hit_way, inv_way, lru_way, way_sel;

  assign in_ready = !pend;
  assign take     = in_valid && in_ready;
  assign go       = pend || (take && in_op != OP_FETCH);
  assign acc_addr = pend ? pend_addr : in_addr;
  assign set_i    = (SET_BITS > 0) ? acc_addr[OFF_BITS +: SIDX_W] : '0;
  assign tag_i    = acc_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    hit = 1'b0; hit_way = '0;
    have_inv = 1'b0; inv_way = '0;
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld[set_i][w] && tags[set_i][w] == tag_i) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld[set_i][w]) begin
        have_inv = 1'b1; inv_way = WAY_W'(w);
      end
    for (int w = 0; w < WAYS; w++)
      if (age[set_i][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
  end

  assign way_sel = hit ? hit_way : (have_inv ? inv_way : lru_way);
  assign evict   = !hit && !have_inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w] <= 1'b0;
          tags[s][w] <= '0;
          age[s][w] <= WAY_W'(w);
        end
    end else if (go) begin
      vld[set_i][way_sel]  <= 1'b1;
      tags[set_i][way_sel] <= tag_i;
      for (int w = 0; w < WAYS; w++)
        if (WAY_W'(w) == way_sel) age[set_i][w] <= '0;
        else if (age[set_i][w] < age[set_i][way_sel]) age[set_i][w] <= age[set_i][w] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; pend_addr <= '0;
      res_valid <= 1'b0; res_hit <= 1'b0; res_miss <= 1'b0; res_evict <= 1'b0;
      hit_cnt <= '0; miss_cnt <= '0; evict_cnt <= '0; access_cnt <= '0;
    end else begin
      pend <= take && in_op == OP_MOD;
      if (take) pend_addr <= in_addr;
      res_valid <= go;
      res_hit   <= go && hit;
      res_miss  <= go && !hit;
      res_evict <= go && evict;
      if (go) begin
        access_cnt <= access_cnt + 1'b1;
        if (hit) hit_cnt <= hit_cnt + 1'b1;
        else miss_cnt <= miss_cnt + 1'b1;
        if (evict) evict_cnt <= evict_cnt + 1'b1;
      end
    end
  end

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_hit != res_miss));
  assert_evict_is_miss_R4: assert property (@(posedge clk) disable iff (rst)
    res_evict |-> (res_miss && res_valid));
  assert_modify_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == OP_MOD) |=> !in_ready);
  assert_modify_store_hits_R6: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (res_valid && res_hit));
  assert_fetch_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == OP_FETCH) |=>
      (!res_valid && $stable(access_cnt) && $stable(hit_cnt) && $stable(miss_cnt) && $stable(evict_cnt)));
  assert_access_count_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (access_cnt == $past(access_cnt) + CNT_W'(1)));
  assert_miss_count_R9: assert property (@(posedge clk) disable iff (rst)
    res_miss |-> (miss_cnt == $past(miss_cnt) + CNT_W'(1)));
endmodule

// File: tb/tb_cache_tag_lru.sv
`timescale 1ns/1ps
module tb_cache_tag_lru;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_op = 2'd0;
  logic [31:0] in_addr = '0;
  logic in_ready, res_valid, res_hit, res_miss, res_evict;
  logic [31:0] hit_cnt, miss_cnt, evict_cnt, access_cnt;
  logic dm_ready, dm_valid, dm_hit, dm_miss, dm_evict;
  logic [31:0] dm_hits, dm_misses, dm_evicts, dm_accs;
  int n_chk = 0, n_fail = 0;
  int e_hit = 0, e_miss = 0, e_ev = 0, e_acc = 0;

  always #2.5 clk = ~clk;

  cache_tag_lru dut (.clk, .rst, .in_valid, .in_ready, .in_op, .in_addr,
    .res_valid, .res_hit, .res_miss, .res_evict,
    .hit_cnt, .miss_cnt, .evict_cnt, .access_cnt);

  cache_tag_lru #(.SET_BITS(4), .WAYS(1), .OFF_BITS(4)) dut_dm (.clk, .rst, .in_valid,
    .in_ready(dm_ready), .in_op, .in_addr, .res_valid(dm_valid), .res_hit(dm_hit),
    .res_miss(dm_miss), .res_evict(dm_evict), .hit_cnt(dm_hits), .miss_cnt(dm_misses),
    .evict_cnt(dm_evicts), .access_cnt(dm_accs));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_res(input bit dm, input string req, input bit eh, input bit ee);
    check({req, " valid"}, dm ? dm_valid : res_valid, 1);
    check({req, " hit"},   dm ? dm_hit   : res_hit,   eh);
    check({req, " miss"},  dm ? dm_miss  : res_miss,  !eh);
    check({req, " evict"}, dm ? dm_evict : res_evict, ee);
    if (!dm) begin
      e_acc++;
      if (eh) e_hit++; else e_miss++;
      if (ee) e_ev++;
    end
  endtask

  // Result is registered on the edge that takes the op: sample at the next falling edge (R11)
  task automatic op1(input logic [1:0] op, input logic [31:0] a, input bit dm,
                     input bit eh, input bit ee, input string req);
    @(negedge clk); in_valid = 1'b1; in_op = op; in_addr = a;
    @(negedge clk); in_valid = 1'b0;
    chk_res(dm, req, eh, ee);
    if (op == 2'd3) begin
      check({req, " R6 stall"}, dm ? dm_ready : in_ready, 0);
      @(negedge clk);
      chk_res(dm, {req, " R6 store part"}, 1'b1, 1'b0);
      check({req, " R6 ready again"}, dm ? dm_ready : in_ready, 1);
    end
  endtask

  task automatic chk_cnts(input string req);
    check({req, " R9 hits"}, hit_cnt, e_hit);
    check({req, " R9 misses"}, miss_cnt, e_miss);
    check({req, " R9 evicts"}, evict_cnt, e_ev);
    check({req, " R9 accesses"}, access_cnt, e_acc);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    e_hit = 0; e_miss = 0; e_ev = 0; e_acc = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R10 res_valid", res_valid, 0);
    check("R10 ready", in_ready, 1);
    chk_cnts("R10");
  endtask

  task automatic t_direct_mapped_example();
    do_reset();
    op1(2'd1, 32'h10,  1, 0, 0, "R12 L10");
    op1(2'd3, 32'h20,  1, 0, 0, "R12 M20");
    op1(2'd1, 32'h22,  1, 1, 0, "R12 L22");
    op1(2'd2, 32'h18,  1, 1, 0, "R12 S18");
    op1(2'd1, 32'h110, 1, 0, 1, "R12 L110");
    op1(2'd1, 32'h210, 1, 0, 1, "R12 L210");
    op1(2'd3, 32'h12,  1, 0, 1, "R12 M12");
    check("R12 hits", dm_hits, 4);
    check("R12 misses", dm_misses, 5);
    check("R12 evicts", dm_evicts, 3);
    check("R12 accesses", dm_accs, 9);
  endtask

  task automatic t_fill_and_hit();
    do_reset();
    op1(2'd1, 32'h000, 0, 0, 0, "R3 fill way0");
    op1(2'd1, 32'h040, 0, 0, 0, "R3 fill way1");
    op1(2'd1, 32'h080, 0, 0, 0, "R3 fill way2");
    op1(2'd1, 32'h0C0, 0, 0, 0, "R3 fill way3");
    op1(2'd1, 32'h008, 0, 1, 0, "R1 R2 offset hit");
    chk_cnts("fill");
  endtask

  task automatic t_lru_evict();
    op1(2'd1, 32'h100, 0, 0, 1, "R4 evict 0x040");
    op1(2'd1, 32'h040, 0, 0, 1, "R4 R5 evict 0x080");
    op1(2'd1, 32'h080, 0, 0, 1, "R4 R5 evict 0x0C0");
    op1(2'd1, 32'h000, 0, 1, 0, "R5 kept 0x000");
    op1(2'd1, 32'h0C0, 0, 0, 1, "R5 evict 0x100");
    op1(2'd1, 32'h040, 0, 1, 0, "R5 kept 0x040");
    op1(2'd1, 32'h100, 0, 0, 1, "R5 evict 0x080");
    chk_cnts("lru");
  endtask

  task automatic t_store_modify();
    op1(2'd1, 32'h010, 0, 0, 0, "R1 other set empty");
    op1(2'd2, 32'h210, 0, 0, 0, "R8 store miss");
    op1(2'd1, 32'h210, 0, 1, 0, "R8 store allocated");
    op1(2'd3, 32'h310, 0, 0, 0, "R6 modify miss");
    op1(2'd3, 32'h310, 0, 1, 0, "R6 modify hit");
    chk_cnts("modify");
  endtask

  task automatic t_fetch_ignored();
    @(negedge clk); in_valid = 1'b1; in_op = 2'd0; in_addr = 32'h410;
    @(negedge clk); in_valid = 1'b0;
    check("R7 no result", res_valid, 0);
    check("R7 ready", in_ready, 1);
    chk_cnts("R7");
    op1(2'd1, 32'h410, 0, 0, 0, "R7 fetch did not allocate");
    op1(2'd1, 32'h010, 0, 1, 0, "R7 set contents kept");
    chk_cnts("R7 after");
  endtask

  task automatic t_reset_clears();
    do_reset();
    chk_cnts("R10 second");
    op1(2'd1, 32'h000, 0, 0, 0, "R10 valid bits cleared");
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_direct_mapped_example();
    t_fill_and_hit();
    t_lru_evict();
    t_store_modify();
    t_fetch_ignored();
    t_reset_clears();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule